// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between a synchronous requester and an external asynchronous static RAM of 256K words by 16 bits with two byte lanes. The requester issues one single-word read or write at a time through a request/ready handshake. The controller turns that request into chip-select, output-enable, write-enable and byte-strobe waveforms whose phase lengths are whole numbers of clock cycles. Each length is derived from the memory's nanosecond timing limits and the clock period, which are all parameters.

A read selects the chip and lowers the output enable for the read phase. The controller samples the data bus on the last cycle of that phase and returns the word with a one-cycle ready pulse. A write starts with a turnaround phase in which the chip is selected and the bus is not driven. The write-enable pulse follows, and then one recovery cycle in which the controller still drives the data. Byte enables pick the lanes through active-low strobes. Lanes that are not enabled read back as zero.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, and whenever no operation is in progress, the memory side is in standby: mem_ce_no=1, mem_ce2_o=0, mem_oe_no=1, mem_we_no=1, mem_lb_no=1, mem_ub_no=1, mem_dq_oe_o=0. ready_o is 0 after reset.
- R2: A request (req_i=1) is accepted only at a clock edge where the controller is idle. req_i and the request fields have no effect while an operation is in progress.
- R3: A read (we_i=0) holds the chip selected (mem_ce_no=0, mem_ce2_o=1), mem_oe_no=0 and mem_we_no=1 for RD cycles, where RD is the largest of ceil(T_RC/CLK), ceil(T_AA/CLK) and ceil(T_OE/CLK), with a floor of 1. These cycles start in the cycle after acceptance.
- R4: Read data is sampled from mem_dq_i at the edge that ends the last read cycle. Lanes that are not enabled return zero (bits 7:0 follow be_i[0], bits 15:8 follow be_i[1]). rdata_o holds its value until the next read completes.
- R5: A write begins with SU setup cycles, SU = max(1, ceil(T_OHZ/CLK)). In these cycles the chip is selected, mem_oe_no=1, mem_we_no=1 and the bus is not driven.
- R6: The write-enable pulse (mem_we_no=0, mem_oe_no=1) lasts PU cycles. PU is the largest of ceil(T_WP/CLK), ceil(T_AW/CLK)-SU, ceil(T_BW/CLK)-SU, ceil(T_DW/CLK), ceil(T_WC/CLK)-SU-1 and 1. One recovery cycle with the chip still selected follows.
- R7: mem_dq_oe_o is 1 exactly during the write-enable pulse and the recovery cycle, and it is never 1 while mem_oe_no=0.
- R8: Byte strobes are active low: mem_lb_no=~be_i[0] gates bits 7:0 and mem_ub_no=~be_i[1] gates bits 15:8, for the whole operation. A write changes only the enabled lanes.
- R9: mem_addr_o and mem_dq_o hold the accepted address and write data, unchanged, for the whole operation.
- R10: ready_o is a single-cycle pulse in the first idle cycle after each operation, one per accepted request. A new request may be accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte enables, bit 0 low lane, bit 1 high lane |
| ready_o | output | 1 | Completion pulse |
| rdata_o | output | 16 | Read data |
| mem_addr_o | output | 18 | Memory address |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_ce2_o | output | 1 | Chip enable, active high |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_lb_no | output | 1 | Lower byte strobe, active low |
| mem_ub_no | output | 1 | Upper byte strobe, active low |
| mem_dq_o | output | 16 | Data bus value driven by the controller |
| mem_dq_oe_o | output | 1 | Data bus drive enable |
| mem_dq_i | input | 16 | Data bus value seen by the controller |

## Verification
The bench builds the controller with a 10 ns clock and the 55 ns speed-grade limits. That gives a six-cycle read, a two-cycle turnaround set by the output release time, and a five-cycle write pulse set by the pulse width rather than by the lead times. A behavioural memory on the bench side applies lane-masked writes when write enable rises. For lanes that are not enabled it returns a fixed filler pattern, so the read-back zeroing of disabled lanes is exercised. The sequence covers back-to-back requests accepted in the ready cycle, requests held high during operations with changing fields, all four byte-enable patterns, and the lowest and highest addresses.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WSET,
    ST_WPUL,
    ST_WREC
  } ctl_st_e;

  // nanoseconds to cycles, rounded up, never below one
  function automatic int cyc_of(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_timer.sv
module sram_ctrl_timer #(
  parameter int CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // phase lengths rely on a strict one-per-cycle countdown
  p_count_down_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_zero_holds_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CW    = 4,
  parameter int RD_LD = 5,
  parameter int SU_LD = 1,
  parameter int PU_LD = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          zero_i,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic          accept_o,
  output logic          cap_o,
  output logic          ready_o,
  output logic          sel_o,
  output logic          oe_o,
  output logic          we_o,
  output logic          drive_o
);

  ctl_st_e st_q, st_d;
  logic    done;

  always_comb begin
    st_d       = st_q;
    load_o     = 1'b0;
    load_val_o = '0;
    accept_o   = 1'b0;
    cap_o      = 1'b0;
    done       = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        accept_o = 1'b1;
        load_o   = 1'b1;
        if (we_i) begin
          st_d       = ST_WSET;
          load_val_o = CW'(SU_LD);
        end else begin
          st_d       = ST_RD;
          load_val_o = CW'(RD_LD);
        end
      end
      ST_RD: if (zero_i) begin
        st_d  = ST_IDLE;
        cap_o = 1'b1;
        done  = 1'b1;
      end
      ST_WSET: if (zero_i) begin
        st_d       = ST_WPUL;
        load_o     = 1'b1;
        load_val_o = CW'(PU_LD);
      end
      ST_WPUL: if (zero_i) st_d = ST_WREC;
      ST_WREC: begin
        st_d = ST_IDLE;
        done = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      ready_o <= 1'b0;
    end else begin
      st_q    <= st_d;
      ready_o <= done;
    end
  end

  assign sel_o   = (st_q != ST_IDLE);
  assign oe_o    = (st_q == ST_RD);
  assign we_o    = (st_q == ST_WPUL);
  assign drive_o = (st_q == ST_WPUL) || (st_q == ST_WREC);

  p_ready_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);

  p_pulse_after_setup_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(we_o) |-> ($past(st_q) == ST_WSET));

  p_busy_ignores_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o && req_i) |-> !load_o || (st_q == ST_WSET));

endmodule

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath #(
  parameter int AW = 18,
  parameter int DW = 16,
  parameter int NB = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          cap_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [NB-1:0] be_i,
  input  logic [DW-1:0] dq_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic [NB-1:0] be_o,
  output logic [DW-1:0] rdata_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o  <= '0;
      wdata_o <= '0;
      be_o    <= '0;
    end else if (accept_i) begin
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
      be_o    <= be_i;
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    rdata_o[b*8 +: 8] <= '0;
      else if (cap_i) rdata_o[b*8 +: 8] <= be_o[b] ? dq_i[b*8 +: 8] : 8'h00;
    end
  end

  p_capture_masked_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !be_o[0]) |=> (rdata_o[7:0] == 8'h00));

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW       = 18,
  parameter int DW       = 16,
  parameter int CLK_NS   = 10,
  parameter int T_RC_NS  = 55,
  parameter int T_AA_NS  = 55,
  parameter int T_OE_NS  = 30,
  parameter int T_WC_NS  = 55,
  parameter int T_WP_NS  = 45,
  parameter int T_AW_NS  = 50,
  parameter int T_BW_NS  = 45,
  parameter int T_DW_NS  = 25,
  parameter int T_OHZ_NS = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [1:0]    be_i,
  output logic          ready_o,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce_no,
  output logic          mem_ce2_o,
  output logic          mem_oe_no,
  output logic          mem_we_no,
  output logic          mem_lb_no,
  output logic          mem_ub_no,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int NB     = DW / 8;
  localparam int RD_CYC = imax(imax(cyc_of(T_RC_NS, CLK_NS), cyc_of(T_AA_NS, CLK_NS)),
                               cyc_of(T_OE_NS, CLK_NS));
  localparam int SU_CYC = cyc_of(T_OHZ_NS, CLK_NS);
  localparam int PU_A   = imax(cyc_of(T_WP_NS, CLK_NS), cyc_of(T_DW_NS, CLK_NS));
  localparam int PU_B   = imax(cyc_of(T_AW_NS, CLK_NS), cyc_of(T_BW_NS, CLK_NS)) - SU_CYC;
  localparam int PU_C   = cyc_of(T_WC_NS, CLK_NS) - SU_CYC - 1;
  localparam int PU_CYC = imax(imax(PU_A, PU_B), imax(PU_C, 1));
  localparam int CW     = $clog2(imax(imax(RD_CYC, SU_CYC), PU_CYC)) + 1;

  logic          load, zero, accept, cap;
  logic [CW-1:0] load_val;
  logic          sel, oe, we, drive;
  logic [NB-1:0] be_q;

  sram_ctrl_timer #(.CW(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .zero_o     (zero)
  );

  sram_ctrl_fsm #(
    .CW    (CW),
    .RD_LD (RD_CYC - 1),
    .SU_LD (SU_CYC - 1),
    .PU_LD (PU_CYC - 1)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .zero_i     (zero),
    .load_o     (load),
    .load_val_o (load_val),
    .accept_o   (accept),
    .cap_o      (cap),
    .ready_o    (ready_o),
    .sel_o      (sel),
    .oe_o       (oe),
    .we_o       (we),
    .drive_o    (drive)
  );

  sram_ctrl_datapath #(.AW(AW), .DW(DW), .NB(NB)) u_dp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .cap_i    (cap),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .be_i     (be_i[NB-1:0]),
    .dq_i     (mem_dq_i),
    .addr_o   (mem_addr_o),
    .wdata_o  (mem_dq_o),
    .be_o     (be_q),
    .rdata_o  (rdata_o)
  );

  assign mem_ce_no   = ~sel;
  assign mem_ce2_o   = sel;
  assign mem_oe_no   = ~oe;
  assign mem_we_no   = ~we;
  assign mem_dq_oe_o = drive;
  assign mem_lb_no   = ~(sel & be_q[0]);
  assign mem_ub_no   = ~(sel & be_q[NB-1]);

  p_standby_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ce_no |-> (!mem_ce2_o && mem_oe_no && mem_we_no && mem_lb_no && mem_ub_no && !mem_dq_oe_o));

  p_no_drive_oe_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);

  p_drive_tail_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> mem_dq_oe_o);

  p_we_oe_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> mem_oe_no);

  p_addr_stable_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no)) |-> ($stable(mem_addr_o) && $stable(mem_dq_o)));

  p_end_ready_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_ce_no) |-> ready_o);

endmodule

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;

  localparam int CLK_NS = 10;

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_RD = mx(mx(cdiv(55), cdiv(55)), cdiv(30));
  localparam int E_SU = cdiv(20);
  localparam int E_PU = mx(mx(mx(cdiv(45), cdiv(25)), mx(cdiv(50) - E_SU, cdiv(45) - E_SU)),
                           mx(cdiv(55) - E_SU - 1, 1));

  logic        clk = 0;
  logic        rst_n = 0;
  logic        req = 0, we = 0;
  logic [17:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = '0;
  logic        ready;
  logic [15:0] rdata, dq_o, dq_i;
  logic [17:0] maddr;
  logic        ce_n, ce2, oe_n, we_n, lb_n, ub_n, dq_oe;

  int total = 0, bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  sram_ctrl #(.CLK_NS(CLK_NS)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .ready_o(ready), .rdata_o(rdata),
    .mem_addr_o(maddr), .mem_ce_no(ce_n), .mem_ce2_o(ce2), .mem_oe_no(oe_n),
    .mem_we_no(we_n), .mem_lb_no(lb_n), .mem_ub_no(ub_n), .mem_dq_o(dq_o),
    .mem_dq_oe_o(dq_oe), .mem_dq_i(dq_i)
  );

  // behavioural memory
  logic [15:0] mem [int];
  function automatic logic [15:0] mrd(input logic [17:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 16'h0000;
  endfunction

  always_comb begin
    dq_i = 16'hA5A5;
    if (!ce_n && ce2 && !oe_n && we_n) begin
      if (!lb_n) dq_i[7:0]  = mrd(maddr)[7:0];
      if (!ub_n) dq_i[15:8] = mrd(maddr)[15:8];
    end
  end

  logic        prev_we_n = 1;
  logic [15:0] lat_d;
  logic [17:0] lat_a;
  logic        lat_lb, lat_ub;
  always @(negedge clk) begin
    if (!we_n) begin
      lat_d = dq_o; lat_a = maddr; lat_lb = !lb_n; lat_ub = !ub_n;
    end else if (!prev_we_n) begin
      logic [15:0] w;
      w = mrd(lat_a);
      if (lat_lb) w[7:0]  = lat_d[7:0];
      if (lat_ub) w[15:8] = lat_d[15:8];
      mem[int'(lat_a)] = w;
    end
    prev_we_n = we_n;
  end

  // reference model, one step per clock
  bit          m_busy, m_we, m_ready;
  int          m_s, m_len;
  logic [17:0] m_addr;
  logic [15:0] m_d, m_rdata;
  logic [1:0]  m_be;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_ready = 0; m_s = 0; m_rdata = '0;
    end else if (!m_busy) begin
      m_ready = 0;
      if (req) begin
        m_busy = 1; m_s = 0; m_we = we; m_addr = addr; m_d = wdata; m_be = be;
        m_len = we ? (E_SU + E_PU + 1) : E_RD;
      end
    end else begin
      m_s++;
      m_ready = 0;
      if (m_s == m_len) begin
        m_busy = 0; m_ready = 1;
        if (!m_we) begin
          m_rdata = mrd(m_addr);
          if (!m_be[0]) m_rdata[7:0] = 8'h00;
          if (!m_be[1]) m_rdata[15:8] = 8'h00;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  bit run_cmp = 0;
  always @(negedge clk) begin
    if (run_cmp) begin
      bit rd_ph, wp_ph, drv;
      rd_ph = m_busy && !m_we;
      wp_ph = m_busy && m_we && m_s >= E_SU && m_s < E_SU + E_PU;
      drv   = m_busy && m_we && m_s >= E_SU;
      chk("R1 chip select", {ce_n, ce2}, {!m_busy, m_busy});
      chk("R3 output enable", oe_n, !rd_ph);
      chk("R6 write enable", we_n, !wp_ph);
      chk("R7 bus drive", dq_oe, drv);
      chk("R8 byte strobes", {ub_n, lb_n}, {!(m_busy && m_be[1]), !(m_busy && m_be[0])});
      chk("R10 ready", ready, m_ready);
      chk("R4 read data", rdata, m_rdata);
      if (m_busy) chk("R9 address", maddr, m_addr);
      if (drv) chk("R9 write data", dq_o, m_d);
      if (dq_oe && !oe_n) chk("R7 drive while oe", 1, 0);
    end
  end

  task automatic op(input bit w, input logic [17:0] a, input logic [15:0] d,
                    input logic [1:0] b, input bit hold);
    req = 1; we = w; addr = a; wdata = d; be = b;
    @(negedge clk);
    if (hold) begin
      // R2: fields change while busy and must be ignored
      addr = ~a; wdata = ~d; be = ~b; we = !w;
    end else req = 0;
    while (!ready) @(negedge clk);
    req = 0;
  endtask

  task automatic rd_chk(input logic [17:0] a, input logic [1:0] b, input logic [15:0] exp,
                        input string tag);
    op(0, a, 16'h0, b, 0);
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset ce_n", ce_n, 1);
    chk("R1 reset ce2", ce2, 0);
    chk("R1 reset oe/we", {oe_n, we_n}, 2'b11);
    chk("R1 reset strobes", {lb_n, ub_n}, 2'b11);
    chk("R1 reset drive", dq_oe, 0);
    chk("R1 reset ready", ready, 0);
    rst_n = 1;
    @(negedge clk);
    run_cmp = 1;
    repeat (2) @(negedge clk);

    op(1, 18'h00010, 16'h1234, 2'b11, 0);
    rd_chk(18'h00010, 2'b11, 16'h1234, "R4 full word read");
    op(1, 18'h3FFFF, 16'hABCD, 2'b11, 0);
    op(1, 18'h3FFFF, 16'h5678, 2'b10, 0);          // R8 upper lane only
    rd_chk(18'h3FFFF, 2'b11, 16'h56CD, "R8 upper lane write");
    op(1, 18'h3FFFF, 16'h00EE, 2'b01, 1);          // R2 held request
    @(negedge clk);
    rd_chk(18'h3FFFF, 2'b01, 16'h00EE, "R4 lower lane read");
    rd_chk(18'h3FFFF, 2'b10, 16'h5600, "R4 upper lane read");
    rd_chk(18'h3FFFF, 2'b00, 16'h0000, "R4 no lane read");
    op(1, 18'h00000, 16'hFFFF, 2'b00, 0);          // R8 no lane write
    rd_chk(18'h00000, 2'b11, 16'h0000, "R8 masked write");
    // back-to-back in the ready cycle (R10)
    for (int i = 0; i < 12; i++) begin
      logic [17:0] a;
      a = 18'(i * 18'h1357);
      op(1, a, 16'(i * 16'h1111 + 3), 2'b11, i[0]);
      rd_chk(a, 2'b11, 16'(i * 16'h1111 + 3), "R3 read after write");
    end
    // pseudo-random mix
    for (int i = 0; i < 40; i++) begin
      bit w;
      w = $urandom_range(0, 1) == 1;
      op(w, 18'($urandom_range(0, 7)), 16'($urandom), 2'($urandom_range(0, 3)),
         $urandom_range(0, 1) == 1);
      if ($urandom_range(0, 1) == 1) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    chk("R1 idle standby", {ce_n, oe_n, we_n, dq_oe}, 4'b1110);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule